// File: doc/BRIEF.md
# PWM Duty-Cycle Averaging Accumulator

This block watches one pulse-width-modulated input and collects the timing of many of its cycles, so that software can later work out average period, average high time, average low time and duty cycle by plain division. The input passes through a synchronizer. A prescaled tick counter measures time. The counter restarts on every rising edge. A falling edge records the high time reached so far. A rising edge records the full period and, at the same moment, closes the cycle in the running totals.

Each accepted cycle adds its period plus a fixed latency compensation to one sum, and its high time plus the same compensation to a second sum. A cycle counter advances alongside them. The low-time total is the difference of the two sums and needs no extra adder chain. After every update the block raises a one-cycle strobe, and from then until the next update the sums and the count form a consistent set. The block makes no measurement until software starts it. The first rising edge after a start only arms the block, because the counter phase before that edge is unknown. A stop freezes everything, and a clear empties the totals.

Top module: `pwm_duty_accum`

## Requirements
- R1: The time counter advances once every (prescale + 1) clocks while running, so a period of T clocks captures floor((T-1)/(prescale+1)).
- R2: A falling edge of the synchronized input loads the current counter value into the high capture and leaves sums, count and strobe unchanged.
- R3: A rising edge loads the current counter value into the period capture and restarts the counter and its prescaler from zero.
- R4: Each accepted rising edge adds (counter value + LAT_COMP) to the period sum and (high capture + LAT_COMP) to the high sum, both modulo 2^SUM_W, and increments the cycle count modulo 2^NUM_W.
- R5: The first rising edge after a start is not accumulated. Accumulation begins with the second rising edge.
- R6: Clear zeroes both sums, the count, both captures, the overflow flag and the counter, and leaves the counter stopped, so that later edges change nothing until a start.
- R7: While stopped, and in the cycle stop is asserted, edges are ignored and the counter is frozen. Sums, count and captures keep their values.
- R8: The low-sum output always equals period sum minus high sum, modulo 2^SUM_W.
- R9: The counter saturates at 2^CNT_W-1 instead of wrapping, so long periods capture the maximum value.
- R10: The overflow flag is set when either sum or the count wraps during an accumulation, and it stays set until a clear.
- R11: The update strobe is high for exactly one cycle after each accumulation and never otherwise.
- R12: After reset every output is zero and the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM signal to measure (asynchronous) |
| start_i | input | 1 | Arm and run the measurement |
| stop_i | input | 1 | Freeze counter and ignore edges |
| clear_i | input | 1 | Zero totals and captures, stop counter |
| prescale_i | input | PRE_W | Tick divider minus one |
| period_sum_o | output | SUM_W | Sum of compensated periods |
| high_sum_o | output | SUM_W | Sum of compensated high times |
| low_sum_o | output | SUM_W | Period sum minus high sum |
| cycles_o | output | NUM_W | Accepted cycle count |
| overflow_o | output | 1 | Sticky wrap indicator |
| update_o | output | 1 | One-cycle pulse after each accumulation |
| period_cap_o | output | CNT_W | Last period capture (uncompensated) |
| high_cap_o | output | CNT_W | Last high-time capture (uncompensated) |

## Verification
The bench builds the block with an 8-bit counter, 12-bit sums, a 4-bit count and a 3-bit prescaler. At these sizes a 300-clock period reaches counter saturation, seventeen such cycles overflow the sums, and sixteen short cycles wrap the count, all within a few thousand clocks. A sweep over several prescale values and period/high pairs, from the shortest legal pulse up to saturation, checks every capture and total against floor-division arithmetic done in the bench. Directed sequences cover stop, restart with the discarded first edge, clear, and how long the overflow flag stays set.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } pwm_edge_t;

  localparam int LANES    = 2;
  localparam int LANE_PER = 0;
  localparam int LANE_HI  = 1;
endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync
  import pwm_duty_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwm_i,
  output pwm_edge_t edge_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_d[g] = pwm_i;
    end else begin : g_next
      assign stg_d[g] = stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      last_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      last_q <= stg_q[STAGES-1];
    end
  end

  assign edge_o.rise = stg_q[STAGES-1] & ~last_q;
  assign edge_o.fall = ~stg_q[STAGES-1] & last_q;
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwm_edge_t        edge_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_cap_o,
  output logic [CNT_W-1:0] hi_cap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q, run_d;
  logic             arm_q, arm_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic             live, rise_ok, fall_ok, tick;
  logic             pre_en, cnt_en, per_en, hi_en;

  always_comb begin
    live    = run_q & ~stop_i & ~clear_i;
    rise_ok = live & edge_i.rise;
    fall_ok = live & edge_i.fall;
    tick    = run_q & (pre_q >= prescale_i);

    run_d = run_q;
    if (clear_i || stop_i) run_d = 1'b0;
    else if (start_i)      run_d = 1'b1;

    arm_d = arm_q;
    if (start_i && !clear_i && !stop_i) arm_d = 1'b1;
    else if (rise_ok)                   arm_d = 1'b0;

    pre_en = clear_i | rise_ok | run_q;
    pre_d  = (clear_i || rise_ok || tick) ? '0 : pre_q + 1'b1;

    cnt_en = clear_i | rise_ok | (tick & (cnt_q != CNT_MAX));
    cnt_d  = (clear_i || rise_ok) ? '0 : cnt_q + 1'b1;

    per_en = clear_i | rise_ok;
    per_d  = clear_i ? '0 : cnt_q;

    hi_en  = clear_i | fall_ok;
    hi_d   = clear_i ? '0 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      run_q <= run_d;
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  assign accept_o  = rise_ok & ~arm_q;
  assign cnt_o     = cnt_q;
  assign per_cap_o = per_q;
  assign hi_cap_o  = hi_q;
endmodule

// File: rtl/pwm_sum_bank.sv
module pwm_sum_bank
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SUM_W    = 48,
  parameter int NUM_W    = 32,
  parameter int LAT_COMP = 82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic [SUM_W-1:0] per_sum_o,
  output logic [SUM_W-1:0] hi_sum_o,
  output logic [NUM_W-1:0] num_o,
  output logic             ovf_o,
  output logic             upd_o
);
  localparam int               ADD_W    = SUM_W + 1;
  localparam logic [ADD_W-1:0] COMP_EXT = ADD_W'(LAT_COMP);

  logic [CNT_W-1:0] lane_in  [LANES];
  logic [SUM_W-1:0] lane_sum [LANES];
  logic [LANES-1:0] carry;
  logic [NUM_W-1:0] num_q, num_d;
  logic [NUM_W:0]   num_wide;
  logic             ovf_q, ovf_d, upd_q;
  logic             acc_en;

  assign lane_in[LANE_PER] = per_i;
  assign lane_in[LANE_HI]  = hi_i;
  assign acc_en            = clear_i | accept_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADD_W-1:0] wide;
    logic [SUM_W-1:0] acc_q, acc_d;

    always_comb begin
      wide  = {1'b0, acc_q} + ADD_W'(lane_in[g]) + COMP_EXT;
      acc_d = clear_i ? '0 : wide[SUM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (acc_en) acc_q <= acc_d;
    end

    assign carry[g]    = wide[SUM_W];
    assign lane_sum[g] = acc_q;
  end

  always_comb begin
    num_wide = {1'b0, num_q} + 1'b1;
    num_d    = clear_i ? '0 : num_wide[NUM_W-1:0];
    ovf_d    = clear_i ? 1'b0 : (ovf_q | (|carry) | num_wide[NUM_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_en) begin
      num_q <= num_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= accept_i & ~clear_i;
  end

  assign per_sum_o = lane_sum[LANE_PER];
  assign hi_sum_o  = lane_sum[LANE_HI];
  assign num_o     = num_q;
  assign ovf_o     = ovf_q;
  assign upd_o     = upd_q;
endmodule

// File: rtl/pwm_duty_accum.sv
module pwm_duty_accum
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SUM_W    = 48,
  parameter int NUM_W    = 32,
  parameter int PRE_W    = 16,
  parameter int LAT_COMP = 82,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic [SUM_W-1:0] period_sum_o,
  output logic [SUM_W-1:0] high_sum_o,
  output logic [SUM_W-1:0] low_sum_o,
  output logic [NUM_W-1:0] cycles_o,
  output logic             overflow_o,
  output logic             update_o,
  output logic [CNT_W-1:0] period_cap_o,
  output logic [CNT_W-1:0] high_cap_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  pwm_edge_t        pwm_edge;
  logic             accept;
  logic [CNT_W-1:0] cnt_now;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pwm_in_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pwm_i  (pwm_i),
    .edge_o (pwm_edge)
  );

  pwm_period_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .edge_i     (pwm_edge),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .clear_i    (clear_i),
    .prescale_i (prescale_i),
    .accept_o   (accept),
    .cnt_o      (cnt_now),
    .per_cap_o  (period_cap_o),
    .hi_cap_o   (high_cap_o)
  );

  pwm_sum_bank #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W), .LAT_COMP(LAT_COMP)
  ) u_sums (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept_i  (accept),
    .clear_i   (clear_i),
    .per_i     (cnt_now),
    .hi_i      (high_cap_o),
    .per_sum_o (period_sum_o),
    .hi_sum_o  (high_sum_o),
    .num_o     (cycles_o),
    .ovf_o     (overflow_o),
    .upd_o     (update_o)
  );

  assign low_sum_o = period_sum_o - high_sum_o;
endmodule

// File: rtl/pwm_duty_accum_chk.sv
module pwm_duty_accum_chk #(
  parameter int SUM_W = 48,
  parameter int NUM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             clear_i,
  input logic [SUM_W-1:0] period_sum_o,
  input logic [SUM_W-1:0] high_sum_o,
  input logic [NUM_W-1:0] cycles_o,
  input logic             overflow_o,
  input logic             update_o
);
  // R11: strobe lasts one cycle
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  // R4: every strobe follows a count step of one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (cycles_o == NUM_W'($past(cycles_o) + 1'b1)));

  // R2: without an accumulation or clear the totals stay put
  a_r2_totals_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_o && !$past(clear_i)) |->
      ($stable(cycles_o) && $stable(period_sum_o) && $stable(high_sum_o)));

  // R6: clear empties the totals
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cycles_o == '0 && period_sum_o == '0 && high_sum_o == '0
                 && !overflow_o && !update_o));

  // R7: an edge seen during stop is not accumulated
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !update_o);

  // R10: overflow is sticky until clear
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !clear_i) |=> overflow_o);
endmodule

bind pwm_duty_accum pwm_duty_accum_chk #(.SUM_W(SUM_W), .NUM_W(NUM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_i       (stop_i),
  .clear_i      (clear_i),
  .period_sum_o (period_sum_o),
  .high_sum_o   (high_sum_o),
  .cycles_o     (cycles_o),
  .overflow_o   (overflow_o),
  .update_o     (update_o)
);

// File: tb/pwm_duty_accum_bench.sv
module pwm_duty_accum_bench;
  localparam int CNT_W = 8;
  localparam int SUM_W = 12;
  localparam int NUM_W = 4;
  localparam int PRE_W = 3;
  localparam int LAT   = 82;
  localparam int SMOD  = 4096;
  localparam int CMAX  = 255;
  localparam int LIMIT = 150000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pwm_i, start_i, stop_i, clear_i;
  logic [PRE_W-1:0] prescale_i;
  logic [SUM_W-1:0] period_sum_o, high_sum_o, low_sum_o;
  logic [NUM_W-1:0] cycles_o;
  logic             overflow_o, update_o;
  logic [CNT_W-1:0] period_cap_o, high_cap_o;

  int checks = 0;
  int fails = 0;
  int upd_seen = 0;
  bit timed_out = 1'b0;

  int nv[4] = '{0, 1, 2, 5};
  int pv[5] = '{2, 9, 23, 40, 300};
  int hv[5] = '{1, 4, 17, 1, 150};

  always #2 clk = ~clk;

  always @(negedge clk) if (update_o) upd_seen++;

  pwm_duty_accum #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W), .PRE_W(PRE_W), .LAT_COMP(LAT)
  ) u_pwm_duty_accum (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i), .start_i(start_i),
    .stop_i(stop_i), .clear_i(clear_i), .prescale_i(prescale_i),
    .period_sum_o(period_sum_o), .high_sum_o(high_sum_o), .low_sum_o(low_sum_o),
    .cycles_o(cycles_o), .overflow_o(overflow_o), .update_o(update_o),
    .period_cap_o(period_cap_o), .high_cap_o(high_cap_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear_i = 1'b1; tick(1); clear_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1; tick(1); stop_i = 1'b0;
  endtask

  task automatic pwm_run(input int p, input int h, input int n);
    for (int k = 0; k < n; k++) begin
      pwm_i = 1'b1; tick(h);
      pwm_i = 1'b0; tick(p - h);
    end
  endtask

  function automatic int capv(input int t, input int pre);
    int v;
    v = (t - 1) / (pre + 1);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // Clear, start, then n+1 rises: the first is discarded (R5).
  task automatic run_cfg(input int pre, input int p, input int h, input int n);
    int per, hi, base;
    longint ps, hs, pm, hm;
    bit ov;
    string lb;
    lb = $sformatf("pre=%0d P=%0d H=%0d n=%0d", pre, p, h, n);
    do_clear();
    prescale_i = PRE_W'(pre);
    do_start();
    tick(3);
    base = upd_seen;
    pwm_run(p, h, n + 1);
    tick(6);
    per = capv(p, pre);
    hi  = capv(h, pre);
    ps  = longint'(n) * (per + LAT);
    hs  = longint'(n) * (hi + LAT);
    ov  = (ps >= SMOD) || (hs >= SMOD) || (n > 15);
    pm  = ps % SMOD;
    hm  = hs % SMOD;
    chk({"R1/R3/R9 period capture ", lb}, period_cap_o, per);
    chk({"R2 high capture ", lb}, high_cap_o, hi);
    chk({"R4 period sum ", lb}, period_sum_o, pm);
    chk({"R4 high sum ", lb}, high_sum_o, hm);
    chk({"R8 low sum ", lb}, low_sum_o, (pm - hm + SMOD) % SMOD);
    chk({"R5 cycle count ", lb}, cycles_o, n % 16);
    chk({"R10 overflow ", lb}, overflow_o, ov);
    chk({"R11 strobe pulses ", lb}, upd_seen - base, n);
  endtask

  task automatic main_seq();
    int base;
    rst_n = 1'b0; pwm_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    clear_i = 1'b0; prescale_i = '0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R12: reset state
    chk("R12 period sum at reset", period_sum_o, 0);
    chk("R12 high sum at reset", high_sum_o, 0);
    chk("R12 count at reset", cycles_o, 0);
    chk("R12 overflow at reset", overflow_o, 0);
    chk("R12 captures at reset", {period_cap_o, high_cap_o}, 0);
    // R12: stopped after reset, edges ignored
    pwm_run(9, 4, 3);
    tick(6);
    chk("R12 stopped after reset", cycles_o, 0);
    chk("R12 no capture while stopped", high_cap_o, 0);

    // Sweep prescale and period/high pairs (R1..R5, R8, R9, R11)
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 5; j++)
        run_cfg(nv[i], pv[j], hv[j], 3);

    // R7: stop freezes everything
    run_cfg(0, 9, 4, 2);
    do_stop();
    base = upd_seen;
    pwm_run(9, 4, 4);
    tick(6);
    chk("R7 count frozen", cycles_o, 2);
    chk("R7 period sum frozen", period_sum_o, 2 * (8 + LAT));
    chk("R7 no strobe", upd_seen - base, 0);
    chk("R7 period capture frozen", period_cap_o, 8);
    // R5: restart discards first rise again
    do_start();
    base = upd_seen;
    pwm_run(9, 4, 3);
    tick(6);
    chk("R5 restart count", cycles_o, 4);
    chk("R5 restart strobes", upd_seen - base, 2);
    chk("R5 restart period sum", period_sum_o, 4 * (8 + LAT));

    // R6: clear empties and stops
    do_clear();
    tick(1);
    chk("R6 period sum cleared", period_sum_o, 0);
    chk("R6 high sum cleared", high_sum_o, 0);
    chk("R6 count cleared", cycles_o, 0);
    chk("R6 captures cleared", {period_cap_o, high_cap_o}, 0);
    pwm_run(9, 4, 3);
    tick(6);
    chk("R6 stopped after clear count", cycles_o, 0);
    chk("R6 stopped after clear capture", period_cap_o, 0);

    // R10: sum overflow with saturated periods (R9), then sticky
    run_cfg(0, 300, 150, 17);
    tick(20);
    chk("R10 overflow sticky", overflow_o, 1);
    // R10: count wrap alone
    run_cfg(0, 2, 1, 16);
    do_clear();
    tick(1);
    chk("R10 overflow cleared", overflow_o, 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (LIMIT) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", LIMIT);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule